// File: doc/BRIEF.md
# SMBus Read-Word Target Engine

This block is the target side of the SMBus Read Word transaction. It runs from a fast system clock that oversamples the two open-drain bus lines. A host first addresses the block for writing and sends one command byte. It then issues a repeated start, addresses the block for reading and clocks out a 16-bit word. The block fetches that word through a lookup port: it presents the latched command on `cmd_o`, and the surrounding logic answers on `word_i` with no wait states. The block never drives the data line high. It only pulls the line low through `sda_oe`, and the pad logic turns that into an open-drain output.

The controller is one state machine. `ST_IDLE` waits for a start. `ST_ADDR` shifts in the address byte, and `ST_ADDR_ACK` drives the acknowledge. `ST_CMD` and `ST_CMD_ACK` do the same for the command byte. `ST_WAIT_RS` waits for the repeated start. `ST_TX_LO` and `ST_TX_HI` send the two data bytes. `ST_HACK_LO` and `ST_HACK_HI` sample the host's acknowledge of each byte. `ST_WAIT_STOP` holds the data line released until the stop. `ST_IGNORE` follows a foreign address.

The transitions are as follows:
- Any start goes to `ST_ADDR`.
- Any stop, or an expired clock-high timeout, goes to `ST_IDLE`.
- `ST_ADDR` goes to `ST_ADDR_ACK` on a matching address, or to `ST_IGNORE` otherwise.
- `ST_ADDR_ACK` goes to `ST_CMD` for a write, or to `ST_TX_LO` for a read.
- `ST_CMD` goes to `ST_CMD_ACK`, then to `ST_WAIT_RS`.
- `ST_TX_LO` goes to `ST_HACK_LO`. From there an ACK leads to `ST_TX_HI` and a NACK to `ST_WAIT_STOP`.
- `ST_TX_HI` goes to `ST_HACK_HI`. From there a NACK leads to `ST_WAIT_STOP`, and an ACK leads to `ST_IDLE` with an error pulse.

Top module: `smb_word_target`

## Requirements
- R1: While receiving, the block takes one data bit on each rising SCL edge, most significant bit first. The command byte reaches `cmd_o` exactly as it was sent.
- R2: A falling SDA while SCL is high is a start. It restarts address reception from any state, including in the middle of a byte. A rising SDA while SCL is high is a stop, and it returns the block to idle.
- R3: The address byte holds the 7-bit address (default 7'h0B) in bits 7..1 and the R/W flag in bit 0, where 0 means write and 1 means read. The wire bytes are therefore 0x16 and 0x17. The block pulls SDA low in the acknowledge slot for its own address in either direction, including a read that no command write precedes.
- R4: After any other address, the block leaves the acknowledge slot released. It drives nothing and accepts no command until the next start.
- R5: The block acknowledges the command byte. It updates `cmd_o` and pulses `cmd_stb` for exactly one clock.
- R6: The block samples `word_i` when it accepts a read address. It returns bits 7..0 first and bits 15..8 second, each byte MSB first. A 0 bit is sent by raising `sda_oe`.
- R7: A host ACK of the low byte leads to the high byte. A host NACK of either byte ends the read: SDA stays released until the stop.
- R8: A host ACK of the high byte raises `err_o` for exactly one clock. SDA stays released and the block returns to idle.
- R9: If SCL stays high for TMO_CYC = CLK_HZ/1e6 × TMO_US clocks (6250 by default) outside idle, the block returns to idle and releases SDA. Shorter high phases leave the transaction intact.
- R10: `sda_oe` rises only while the synchronised SCL is low, after a falling edge. The block keeps SDA released during every bit the host drives.
- R11: After a stop, bytes clocked without a start get no acknowledge.
- R12: In reset and after it: `sda_oe` = 0, `err_o` = 0, `cmd_stb` = 0 and `cmd_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low |
| cmd_o | output | 8 | Last command byte received |
| cmd_stb | output | 1 | One-clock pulse when a command is accepted |
| word_i | input | 16 | Word for the command on `cmd_o` |
| err_o | output | 1 | One-clock pulse when the host acknowledges the final byte |

## Verification
A wrong state in this controller shows on `sda_oe` within one SCL bit. A misplaced bit count or a skipped acknowledge state drives the line low in a slot that belongs to the host, or fails to drive it in the block's own slot. The bench compares `sda_oe` against an expected value on every system clock once each bit has settled, so such a fault is caught within about a dozen clocks. A state machine stuck after a timeout or a stop shows up as a missing acknowledge of the next transaction's address. Stray `cmd_stb` or `err_o` pulses are caught by the bench counting those pulses.

// File: rtl/smb_word_pkg.sv
package smb_word_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WAIT_RS,
        ST_TX_LO,
        ST_HACK_LO,
        ST_TX_HI,
        ST_HACK_HI,
        ST_WAIT_STOP,
        ST_IGNORE
    } smb_state_e;

    // Bus events derived from the synchronised lines.
    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } smb_evt_t;

    localparam int LINE_SCL = 0;
    localparam int LINE_SDA = 1;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] pipe_q;
    logic              prev_q;

    // Bus idles high, so all stages reset to 1.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '1;
            prev_q <= 1'b1;
        end else begin
            pipe_q <= {pipe_q[STAGES-2:0], line_i};
            prev_q <= pipe_q[STAGES-1];
        end
    end

    assign level_o = pipe_q[STAGES-1];
    assign rise_o  = level_o & ~prev_q;
    assign fall_o  = ~level_o & prev_q;

endmodule

// File: rtl/smb_bus_events.sv
module smb_bus_events
    import smb_word_pkg::*;
(
    input  logic [1:0] level_i,
    input  logic [1:0] rise_i,
    input  logic [1:0] fall_i,
    output smb_evt_t   evt_o
);
    always_comb begin
        evt_o.scl      = level_i[LINE_SCL];
        evt_o.sda      = level_i[LINE_SDA];
        evt_o.scl_rise = rise_i[LINE_SCL];
        evt_o.scl_fall = fall_i[LINE_SCL];
        // SDA moving while SCL is high is framing, never data.
        evt_o.start    = level_i[LINE_SCL] & fall_i[LINE_SDA];
        evt_o.stop     = level_i[LINE_SCL] & rise_i[LINE_SDA];
    end

endmodule

// File: rtl/smb_hi_timeout.sv
module smb_hi_timeout #(
    parameter int LIMIT = 6250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic scl_i,
    output logic hit_o
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!arm_i || !scl_i) begin
            cnt_q <= '0;
        end else if (cnt_q != CW'(LIMIT)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign hit_o = arm_i & scl_i & (cnt_q == CW'(LIMIT - 1));

    // R9: expiry is only possible after SCL has already been high a cycle.
    p_hit_after_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> $past(scl_i));

endmodule

// File: rtl/smb_word_target.sv
module smb_word_target
    import smb_word_pkg::*;
#(
    parameter logic [6:0] ADDR7       = 7'h0B,
    parameter int         CLK_HZ      = 125_000_000,
    parameter int         TMO_US      = 50,
    parameter int         SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe,
    output logic [7:0]  cmd_o,
    output logic        cmd_stb,
    input  logic [15:0] word_i,
    output logic        err_o
);
    localparam int TMO_CYC = (CLK_HZ / 1_000_000) * TMO_US;
    localparam int BITS    = 8;
    localparam int BCW     = $clog2(BITS + 1);

    logic [1:0] raw_w, lvl_w, rise_w, fall_w;
    smb_evt_t   ev;
    logic       tmo_hit;

    smb_state_e     state_q, state_d;
    logic [BCW-1:0] bit_cnt_q;
    logic [7:0]     rx_q;
    logic [15:0]    word_q;
    logic [7:0]     tx_byte;
    logic           byte_full, adr_hit;

    assign raw_w[LINE_SCL] = scl_i;
    assign raw_w[LINE_SDA] = sda_i;

    for (genvar g = 0; g < 2; g++) begin : g_sync
        smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_i  (raw_w[g]),
            .level_o (lvl_w[g]),
            .rise_o  (rise_w[g]),
            .fall_o  (fall_w[g])
        );
    end

    smb_bus_events u_evt (
        .level_i (lvl_w),
        .rise_i  (rise_w),
        .fall_i  (fall_w),
        .evt_o   (ev)
    );

    smb_hi_timeout #(.LIMIT(TMO_CYC)) u_tmo (
        .clk   (clk),
        .rst_n (rst_n),
        .arm_i (state_q != ST_IDLE),
        .scl_i (ev.scl),
        .hit_o (tmo_hit)
    );

    assign byte_full = (bit_cnt_q == BCW'(BITS));
    assign adr_hit   = (rx_q[7:1] == ADDR7);
    assign tx_byte   = (state_q == ST_TX_HI) ? word_q[15:8] : word_q[7:0];

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (tmo_hit || ev.stop) begin
            state_d = ST_IDLE;
        end else if (ev.start) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_ADDR:      if (ev.scl_fall && byte_full)
                                  state_d = adr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:  if (ev.scl_fall)
                                  state_d = rx_q[0] ? ST_TX_LO : ST_CMD;
                ST_CMD:       if (ev.scl_fall && byte_full) state_d = ST_CMD_ACK;
                ST_CMD_ACK:   if (ev.scl_fall) state_d = ST_WAIT_RS;
                ST_WAIT_RS:   state_d = ST_WAIT_RS;
                ST_TX_LO:     if (ev.scl_fall && byte_full) state_d = ST_HACK_LO;
                ST_HACK_LO:   if (ev.scl_rise)
                                  state_d = ev.sda ? ST_WAIT_STOP : ST_TX_HI;
                ST_TX_HI:     if (ev.scl_fall && byte_full) state_d = ST_HACK_HI;
                ST_HACK_HI:   if (ev.scl_rise)
                                  state_d = ev.sda ? ST_WAIT_STOP : ST_IDLE;
                ST_WAIT_STOP: state_d = ST_WAIT_STOP;
                ST_IGNORE:    state_d = ST_IGNORE;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe    <= 1'b0;
            bit_cnt_q <= '0;
            rx_q      <= '0;
            word_q    <= '0;
            cmd_o     <= '0;
            cmd_stb   <= 1'b0;
            err_o     <= 1'b0;
        end else begin
            cmd_stb <= 1'b0;
            err_o   <= 1'b0;
            if (tmo_hit || ev.stop || ev.start) begin
                sda_oe    <= 1'b0;
                bit_cnt_q <= '0;
            end else begin
                unique case (state_q)
                    ST_ADDR, ST_CMD: begin
                        if (ev.scl_rise && !byte_full) begin
                            rx_q      <= {rx_q[6:0], ev.sda};
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                        end
                        if (ev.scl_fall && byte_full) begin
                            bit_cnt_q <= '0;
                            if (state_q == ST_ADDR) begin
                                sda_oe <= adr_hit;
                                if (adr_hit && rx_q[0]) word_q <= word_i;
                            end else begin
                                sda_oe  <= 1'b1;
                                cmd_o   <= rx_q;
                                cmd_stb <= 1'b1;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (ev.scl_fall) sda_oe <= rx_q[0] ? ~word_q[7] : 1'b0;
                    end
                    ST_CMD_ACK: begin
                        if (ev.scl_fall) sda_oe <= 1'b0;
                    end
                    ST_TX_LO, ST_TX_HI: begin
                        if (ev.scl_rise && !byte_full) bit_cnt_q <= bit_cnt_q + 1'b1;
                        if (ev.scl_fall) begin
                            if (byte_full) begin
                                sda_oe    <= 1'b0;
                                bit_cnt_q <= '0;
                            end else begin
                                sda_oe <= ~tx_byte[3'd7 - bit_cnt_q[2:0]];
                            end
                        end
                    end
                    ST_HACK_HI: begin
                        if (ev.scl_rise && !ev.sda) err_o <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R3: own address is acknowledged throughout the ACK slot
    p_ack_own_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR_ACK) |-> sda_oe);
    // R7: line released in every state where the slave owns no bit
    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q inside {ST_IDLE, ST_WAIT_RS, ST_WAIT_STOP, ST_IGNORE, ST_HACK_LO})
        |-> !sda_oe);
    // R10: pull-down only starts while SCL is low
    p_oe_rise_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !ev.scl);
    // R8: error is a single-cycle pulse and leaves the engine idle
    p_err_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> (!err_o && state_q == ST_IDLE));
    // R5: command strobe lasts one clock
    p_cmd_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |=> !cmd_stb);
    // R9: timeout drops the engine to idle with the line released
    p_tmo_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_hit |=> (state_q == ST_IDLE && !sda_oe));
    // R2: stop always ends the transaction
    p_stop_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ev.stop |=> (state_q == ST_IDLE));

endmodule

// File: tb/smb_word_target_tb.sv
module smb_word_target_tb_top;

    localparam int H = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        sda_h = 1'b1;
    logic        sda_line;
    logic        sda_oe, cmd_stb, err_o;
    logic [7:0]  cmd_o;
    logic [15:0] word_i;

    int    checks = 0;
    int    errors = 0;
    int    stb_seen = 0;
    int    err_seen = 0;
    logic  chk_on = 1'b0;
    logic  exp_oe = 1'b0;
    logic  last_line = 1'b1;
    logic  done = 1'b0;
    string cur_req = "R12";

    always #4 clk = ~clk;

    function automatic logic [15:0] ref_word(input logic [7:0] c);
        return {c ^ 8'h96, ~c};
    endfunction

    assign sda_line = sda_h & ~sda_oe;
    assign word_i   = ref_word(cmd_o);

    smb_word_target dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl),
        .sda_i   (sda_line),
        .sda_oe  (sda_oe),
        .cmd_o   (cmd_o),
        .cmd_stb (cmd_stb),
        .word_i  (word_i),
        .err_o   (err_o)
    );

    // Reference comparison of the pull-down on every settled clock
    always @(negedge clk) begin
        #1;
        if (chk_on) begin
            checks++;
            if (sda_oe !== exp_oe) begin
                errors++;
                $display("FAIL %s: sda_oe=%b expected %b at %0t", cur_req, sda_oe, exp_oe, $time);
            end
        end
        if (cmd_stb === 1'b1) stb_seen++;
        if (err_o === 1'b1) err_seen++;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, expv);
        end
    endtask

    task automatic bus_bit(input logic hb, input logic exp_low, input string tag, input int hold);
        chk_on = 1'b0;
        tick(2);
        sda_h = hb;
        tick(4);
        exp_oe  = exp_low;
        cur_req = tag;
        chk_on  = 1'b1;
        tick(H - 6);
        scl = 1'b1;
        tick(hold / 2);
        last_line = sda_line;
        tick(hold - hold / 2);
        scl = 1'b0;
        chk_on = 1'b0;
    endtask

    task automatic start_cond();
        chk_on = 1'b0;
        if (scl == 1'b0) begin
            tick(2);
            sda_h = 1'b1;
            tick(H);
            scl = 1'b1;
        end
        sda_h = 1'b1;
        tick(H);
        sda_h = 1'b0;
        tick(H);
        scl = 1'b0;
    endtask

    task automatic stop_cond();
        chk_on = 1'b0;
        tick(2);
        sda_h = 1'b0;
        tick(H);
        scl = 1'b1;
        tick(H);
        sda_h = 1'b1;
        tick(H);
    endtask

    task automatic write_byte(input logic [7:0] b, input logic exp_ack, input string tag, input int hold7);
        for (int i = 7; i >= 0; i--) bus_bit(b[i], 1'b0, "R10", (i == 7) ? hold7 : H);
        bus_bit(1'b1, exp_ack, tag, H);
    endtask

    task automatic read_byte(input logic [7:0] expb, input logic host_ack, input string tag);
        logic [7:0] got;
        got = '0;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, ~expb[i], tag, H);
            got[i] = last_line;
        end
        bus_bit(~host_ack, 1'b0, "R7", H);
        check(got == expb, tag, got, expb);
    endtask

    task automatic read_word(input logic [7:0] c, input logic ack_hi, input int hold7);
        logic [15:0] w;
        w = ref_word(c);
        start_cond();
        write_byte(8'h16, 1'b1, "R3", H);
        write_byte(c, 1'b1, "R5", hold7);
        check(cmd_o == c, "R1", cmd_o, c);
        start_cond();
        write_byte(8'h17, 1'b1, "R3", H);
        read_byte(w[7:0], 1'b1, "R6");
        read_byte(w[15:8], ack_hi, "R6");
        stop_cond();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, got 0 expected 1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int s0, e0;
        tick(5);
        check(sda_oe == 1'b0 && err_o == 1'b0 && cmd_stb == 1'b0, "R12", {sda_oe, err_o, cmd_stb}, 0);
        rst_n = 1'b1;
        tick(5);
        check(sda_oe == 1'b0 && cmd_o == 8'h00, "R12", {sda_oe, cmd_o}, 0);

        // Plain reads with different commands (R1, R3, R5, R6, R7)
        s0 = stb_seen;
        read_word(8'h3C, 1'b0, H);
        check(stb_seen == s0 + 1, "R5", stb_seen - s0, 1);
        read_word(8'hC3, 1'b0, H);
        read_word(8'h01, 1'b0, H);
        check(err_seen == 0, "R7", err_seen, 0);

        // Foreign addresses are not answered (R4)
        s0 = stb_seen;
        start_cond();
        write_byte(8'h20, 1'b0, "R4", H);
        write_byte(8'h55, 1'b0, "R4", H);
        stop_cond();
        start_cond();
        write_byte(8'h21, 1'b0, "R4", H);
        for (int i = 0; i < 9; i++) bus_bit(1'b1, 1'b0, "R4", H);
        stop_cond();
        check(stb_seen == s0, "R4", stb_seen - s0, 0);

        // Bytes without a start after a stop (R11)
        chk_on = 1'b0;
        tick(2);
        scl = 1'b0;
        tick(H);
        write_byte(8'h16, 1'b0, "R11", H);
        write_byte(8'h77, 1'b0, "R11", H);
        stop_cond();
        check(stb_seen == s0, "R11", stb_seen - s0, 0);

        // Start in the middle of the command byte (R2)
        start_cond();
        write_byte(8'h16, 1'b1, "R2", H);
        for (int i = 0; i < 3; i++) bus_bit(1'b1, 1'b0, "R2", H);
        start_cond();
        write_byte(8'h17, 1'b1, "R2", H);
        read_byte(ref_word(8'h01) & 16'h00FF, 1'b0, "R2");
        stop_cond();
        check(cmd_o == 8'h01, "R2", cmd_o, 8'h01);

        // Host acknowledges the final byte (R8)
        e0 = err_seen;
        read_word(8'h5A, 1'b1, H);
        check(err_seen == e0 + 1, "R8", err_seen - e0, 1);
        check(sda_oe == 1'b0, "R8", sda_oe, 0);

        // Clock held high past the limit aborts (R9)
        s0 = stb_seen;
        start_cond();
        write_byte(8'h16, 1'b1, "R9", H);
        write_byte(8'hA7, 1'b0, "R9", 7000);
        write_byte(8'h16, 1'b0, "R9", H);
        stop_cond();
        check(stb_seen == s0, "R9", stb_seen - s0, 0);

        // Held high just under the limit keeps going (R9)
        read_word(8'hE4, 1'b0, 5000);
        check(stb_seen == s0 + 1, "R9", stb_seen - s0, 1);
        check(cmd_o == 8'hE4, "R9", cmd_o, 8'hE4);

        // Read without a command write in the same transaction (R3)
        start_cond();
        write_byte(8'h17, 1'b1, "R3", H);
        read_byte(ref_word(8'hE4) & 16'h00FF, 1'b0, "R7");
        for (int i = 0; i < 9; i++) bus_bit(1'b1, 1'b0, "R7", H);
        stop_cond();

        tick(20);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule